// File: doc/BRIEF.md
# Subclock Idle Controller

This block decides when a system that is already running from its slow subclock may drop into a deep idle state, and when it must come back out. Software writes a small control word: a 2-bit power-save mode, a stop request bit and three wake-disable bits. When the stop bit is set, the system reports subclock operation and the mode is one of the two idle codes, the block turns off the clock enables of the CPU, the flash and the general peripherals. The oscillator enable and the clock enable of subclock-capable peripherals stay on throughout. The PLL enable is saved at this point and forced off while idle.

Wake requests come from two non-maskable lines, a bank of external interrupt pins and a bank of internal peripheral interrupts, each maskable bit by bit. A request that is unmasked and not disabled ends the idle state whatever its priority. A fixed wake delay of subclock cycles is then counted before the clocks return. The system stays in subclock operation after an interrupt wake. An asynchronous reset returns the block to its run state at once.

Top module: `subidle_top`

## Requirements
- R1: With `onSubclk`=1, the stored mode equal to 2'b00 or 2'b10 and the stored stop bit equal to 1, and no wake request active, `stat` changes from RUN (2'd0) to IDLE (2'd2) on the clock edge after the write that set the stop bit.
- R2: A stored mode of 2'b01 or 2'b11, or `onSubclk`=0, prevents entry: `stat` stays RUN and `stopFlag` stays 1.
- R3: `cpuClkEn`, `flashClkEn` and `perClkEn` are 1 in RUN and 0 in IDLE and WAKE (2'd1); `oscEn` and `subPerClkEn` are 1 in every state.
- R4: In IDLE, a wake is raised by `nmiReq[0]`, `nmiReq[1]`, any `extIrq` bit whose `extMask` bit is 0, or any `intIrq` bit whose `intMask` bit is 0; a masked bit (mask bit 1) does not wake.
- R5: A stored `nmiDis[i]`=1 blocks wake by `nmiReq[i]`, and a stored interrupt-disable bit of 1 blocks wake by all `extIrq` and `intIrq` lines; a blocked request leaves `stat` at IDLE.
- R6: If a wake request is active on the edge where entry would occur, `stat` stays RUN, the clock enables never drop, and `stopFlag` clears.
- R7: A wake request sampled at clock edge E moves `stat` to WAKE after E; `stat` returns to RUN after edge E+12 (WAKE_CYC=12), and requests during WAKE have no effect.
- R8: The stop bit clears on entry and on an aborted entry; control writes (`ctlWrEn`) are ignored while `stat` is not RUN.
- R9: `clkSelSub` is set when IDLE is entered and stays 1 after an interrupt wake returns to RUN.
- R10: `pllEn` is 0 in IDLE, equals the value of `pllReq` captured at entry while in WAKE, and follows `pllReq` in RUN.
- R11: Asserting `rstN` low forces `stat` to RUN, the clock enables on, and `stopFlag` and `clkSelSub` to 0 without waiting for a clock edge or the wake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subclock |
| rstN | input | 1 | Asynchronous active-low reset |
| onSubclk | input | 1 | System is in subclock operation |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlMode | input | 2 | Power-save mode field |
| ctlStop | input | 1 | Stop request bit |
| ctlNmiDis | input | 2 | Per-line non-maskable wake disable |
| ctlIntDis | input | 1 | Maskable interrupt wake disable |
| pllReq | input | 1 | Requested PLL enable in run |
| nmiReq | input | 2 | Non-maskable wake requests |
| extIrq | input | NUM_EXT | External interrupt pin requests |
| extMask | input | NUM_EXT | External interrupt masks, 1 = masked |
| intIrq | input | NUM_INT | Internal peripheral interrupt requests |
| intMask | input | NUM_INT | Internal interrupt masks, 1 = masked |
| cpuClkEn | output | 1 | CPU clock enable |
| flashClkEn | output | 1 | Flash clock enable |
| perClkEn | output | 1 | General peripheral clock enable |
| subPerClkEn | output | 1 | Subclock-capable peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| pllEn | output | 1 | PLL enable |
| clkSelSub | output | 1 | Subclock operation selected after wake |
| stopFlag | output | 1 | Current stop bit |
| stat | output | 2 | 0 run, 1 wake delay, 2 idle |

## Verification
The bench uses the default parameters: eight external pins, four internal interrupt lines and a 12-cycle wake delay. With these, every single-line wake path, each disable bit and the exact delay boundary can be hit individually, and the 12-cycle window is short enough to hold a reset in the middle of it. A behavioural model tracks the state on every clock and is compared with all outputs.

// File: rtl/subidle_pkg.sv
package subidle_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAKE = 2'd1,
    ST_IDLE = 2'd2
  } idle_state_t;

  typedef struct packed {
    logic enter;   // idle entered: save context, clear stop
    logic abort;   // entry refused by pending request: clear stop
    logic cntClr;  // start of wake delay
    logic cntInc;  // wake delay running
  } idle_strobe_t;
endpackage

// File: rtl/subidle_dp.sv
module subidle_dp
  import subidle_pkg::*;
#(
  parameter int NUM_EXT  = 8,
  parameter int NUM_INT  = 4,
  parameter int WAKE_CYC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  idle_strobe_t       stb,
  input  logic               wrAllow,
  input  logic               inIdle,
  input  logic               inWake,
  input  logic               onSubclk,
  input  logic               ctlWrEn,
  input  logic [1:0]         ctlMode,
  input  logic               ctlStop,
  input  logic [1:0]         ctlNmiDis,
  input  logic               ctlIntDis,
  input  logic               pllReq,
  input  logic [1:0]         nmiReq,
  input  logic [NUM_EXT-1:0] extIrq,
  input  logic [NUM_EXT-1:0] extMask,
  input  logic [NUM_INT-1:0] intIrq,
  input  logic [NUM_INT-1:0] intMask,
  output logic               entryReq,
  output logic               wakeAny,
  output logic               cntDone,
  output logic               stopFlag,
  output logic               pllEn,
  output logic               clkSelSub
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);

  logic [1:0]       modeReg;
  logic [1:0]       nmiDisReg;
  logic             intDisReg;
  logic             stopReg;
  logic             pllSaved;
  logic             selReg;
  logic [CNT_W-1:0] cnt;

  logic [NUM_EXT-1:0] extHit;
  logic [NUM_INT-1:0] intHit;
  logic [1:0]         nmiHit;

  genvar g;
  generate
    for (g = 0; g < NUM_EXT; g++) begin : gExt
      assign extHit[g] = extIrq[g] & ~extMask[g];
    end
    for (g = 0; g < NUM_INT; g++) begin : gInt
      assign intHit[g] = intIrq[g] & ~intMask[g];
    end
    for (g = 0; g < 2; g++) begin : gNmi
      assign nmiHit[g] = nmiReq[g] & ~nmiDisReg[g];
    end
  endgenerate

  logic modeOk;
  assign modeOk   = (modeReg[0] == 1'b0);
  assign entryReq = stopReg & onSubclk & modeOk;
  assign wakeAny  = (|nmiHit) | (((|extHit) | (|intHit)) & ~intDisReg);
  assign cntDone  = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= 2'b00;
      nmiDisReg <= 2'b00;
      intDisReg <= 1'b0;
    end else if (wrAllow && ctlWrEn) begin
      modeReg   <= ctlMode;
      nmiDisReg <= ctlNmiDis;
      intDisReg <= ctlIntDis;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopReg <= 1'b0;
    end else if (stb.enter || stb.abort) begin
      stopReg <= 1'b0;
    end else if (wrAllow && ctlWrEn) begin
      stopReg <= ctlStop;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllSaved <= 1'b0;
      selReg   <= 1'b0;
    end else if (stb.enter) begin
      pllSaved <= pllReq;
      selReg   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.cntClr) begin
      cnt <= '0;
    end else if (stb.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (inIdle)      pllEn = 1'b0;
    else if (inWake) pllEn = pllSaved;
    else             pllEn = pllReq;
  end

  assign stopFlag  = stopReg;
  assign clkSelSub = selReg;
endmodule

// File: rtl/subidle_ctrl.sv
module subidle_ctrl
  import subidle_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         entryReq,
  input  logic         wakeAny,
  input  logic         cntDone,
  output idle_state_t  state,
  output idle_strobe_t stb
);
  idle_state_t nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_RUN: begin
        if (entryReq) begin
          if (wakeAny) begin
            stb.abort = 1'b1;
          end else begin
            stb.enter = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (wakeAny) begin
          stb.cntClr = 1'b1;
          nextState  = ST_WAKE;
        end
      end
      ST_WAKE: begin
        stb.cntInc = 1'b1;
        if (cntDone) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end
endmodule

// File: rtl/subidle_top.sv
module subidle_top
  import subidle_pkg::*;
#(
  parameter int NUM_EXT  = 8,
  parameter int NUM_INT  = 4,
  parameter int WAKE_CYC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               onSubclk,
  input  logic               ctlWrEn,
  input  logic [1:0]         ctlMode,
  input  logic               ctlStop,
  input  logic [1:0]         ctlNmiDis,
  input  logic               ctlIntDis,
  input  logic               pllReq,
  input  logic [1:0]         nmiReq,
  input  logic [NUM_EXT-1:0] extIrq,
  input  logic [NUM_EXT-1:0] extMask,
  input  logic [NUM_INT-1:0] intIrq,
  input  logic [NUM_INT-1:0] intMask,
  output logic               cpuClkEn,
  output logic               flashClkEn,
  output logic               perClkEn,
  output logic               subPerClkEn,
  output logic               oscEn,
  output logic               pllEn,
  output logic               clkSelSub,
  output logic               stopFlag,
  output logic [1:0]         stat
);
  idle_state_t  state;
  idle_strobe_t stb;
  logic entryReq, wakeAny, cntDone;
  logic runNow;

  assign runNow = (state == ST_RUN);

  subidle_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .entryReq(entryReq), .wakeAny(wakeAny),
    .cntDone(cntDone), .state(state), .stb(stb)
  );

  subidle_dp #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .WAKE_CYC(WAKE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAllow(runNow),
    .inIdle(state == ST_IDLE), .inWake(state == ST_WAKE),
    .onSubclk(onSubclk), .ctlWrEn(ctlWrEn), .ctlMode(ctlMode),
    .ctlStop(ctlStop), .ctlNmiDis(ctlNmiDis), .ctlIntDis(ctlIntDis),
    .pllReq(pllReq), .nmiReq(nmiReq), .extIrq(extIrq), .extMask(extMask),
    .intIrq(intIrq), .intMask(intMask), .entryReq(entryReq),
    .wakeAny(wakeAny), .cntDone(cntDone), .stopFlag(stopFlag),
    .pllEn(pllEn), .clkSelSub(clkSelSub)
  );

  assign cpuClkEn    = runNow;
  assign flashClkEn  = runNow;
  assign perClkEn    = runNow;
  assign subPerClkEn = 1'b1;
  assign oscEn       = 1'b1;
  assign stat        = state;
endmodule

// File: rtl/subidle_chk.sv
module subidle_chk #(
  parameter int NUM_EXT  = 8,
  parameter int NUM_INT  = 4,
  parameter int WAKE_CYC = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               onSubclk,
  input logic [1:0]         nmiReq,
  input logic [NUM_EXT-1:0] extIrq,
  input logic [NUM_EXT-1:0] extMask,
  input logic [NUM_INT-1:0] intIrq,
  input logic [NUM_INT-1:0] intMask,
  input logic               cpuClkEn,
  input logic               flashClkEn,
  input logic               perClkEn,
  input logic               pllEn,
  input logic               clkSelSub,
  input logic               stopFlag,
  input logic [1:0]         stat
);
  int wakeRun;
  logic quiet;

  assign quiet = (nmiReq == 2'b00) && ((extIrq & ~extMask) == '0) &&
                 ((intIrq & ~intMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wakeRun <= 0;
    else if (stat == 2'd1) wakeRun <= wakeRun + 1;
    else                   wakeRun <= 0;
  end

  p_entry_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat == 2'd2) |-> $past(onSubclk));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stat != 2'd0) |-> (!cpuClkEn && !flashClkEn && !perClkEn));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stat == 2'd2 && quiet) |=> (stat == 2'd2));

  p_wake_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stat == 2'd1) |-> (wakeRun < WAKE_CYC));

  p_wake_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stat == 2'd1 && wakeRun == WAKE_CYC - 1) |=> (stat == 2'd0));

  p_stop_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat == 2'd2) |-> !stopFlag);

  p_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stat == 2'd2) |-> clkSelSub);

  p_pll_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stat == 2'd2) |-> !pllEn);
endmodule

bind subidle_top subidle_chk #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .WAKE_CYC(WAKE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .onSubclk(onSubclk), .nmiReq(nmiReq),
  .extIrq(extIrq), .extMask(extMask), .intIrq(intIrq), .intMask(intMask),
  .cpuClkEn(cpuClkEn), .flashClkEn(flashClkEn), .perClkEn(perClkEn),
  .pllEn(pllEn), .clkSelSub(clkSelSub), .stopFlag(stopFlag), .stat(stat)
);

// File: tb/subidle_top_bench.sv
module subidle_top_bench;
  localparam int NE = 8;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onSubclk = 1'b0, ctlWrEn = 1'b0, ctlStop = 1'b0, ctlIntDis = 1'b0, pllReq = 1'b0;
  logic [1:0] ctlMode = 2'b00, ctlNmiDis = 2'b00, nmiReq = 2'b00;
  logic [NE-1:0] extIrq = '0, extMask = '1;
  logic [NI-1:0] intIrq = '0, intMask = '1;
  logic cpuClkEn, flashClkEn, perClkEn, subPerClkEn, oscEn, pllEn, clkSelSub, stopFlag;
  logic [1:0] stat;

  always #2.5 clk = ~clk;

  subidle_top u_subidle_top (
    .clk(clk), .rstN(rstN), .onSubclk(onSubclk), .ctlWrEn(ctlWrEn),
    .ctlMode(ctlMode), .ctlStop(ctlStop), .ctlNmiDis(ctlNmiDis),
    .ctlIntDis(ctlIntDis), .pllReq(pllReq), .nmiReq(nmiReq),
    .extIrq(extIrq), .extMask(extMask), .intIrq(intIrq), .intMask(intMask),
    .cpuClkEn(cpuClkEn), .flashClkEn(flashClkEn), .perClkEn(perClkEn),
    .subPerClkEn(subPerClkEn), .oscEn(oscEn), .pllEn(pllEn),
    .clkSelSub(clkSelSub), .stopFlag(stopFlag), .stat(stat)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 run, 1 wake delay, 2 idle
  int mState = 0, mLeft = 0, mMode = 0, mNmiDis = 0, mIntDis = 0;
  int mStop = 0, mSaved = 0, mSel = 0;

  function automatic bit wakeSeen();
    bit w = 0;
    for (int i = 0; i < 2; i++)
      if (nmiReq[i] && !mNmiDis[i]) w = 1;
    if (mIntDis == 0) begin
      for (int i = 0; i < NE; i++) if (extIrq[i] && !extMask[i]) w = 1;
      for (int i = 0; i < NI; i++) if (intIrq[i] && !intMask[i]) w = 1;
    end
    return w;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mLeft = 0; mMode = 0; mNmiDis = 0; mIntDis = 0;
      mStop = 0; mSaved = 0; mSel = 0;
    end else begin
      bit w;
      bit go;
      w = wakeSeen();
      if (mState == 0) begin
        go = (mStop == 1) && onSubclk && (mMode == 0 || mMode == 2);
        if (ctlWrEn) begin
          mStop = ctlStop; mMode = ctlMode; mNmiDis = ctlNmiDis; mIntDis = ctlIntDis;
        end
        if (go) begin
          mStop = 0;
          if (!w) begin mState = 2; mSaved = pllReq; mSel = 1; end
        end
      end else if (mState == 2) begin
        if (w) begin mState = 1; mLeft = 12; end
      end else begin
        mLeft--;
        if (mLeft == 0) mState = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rstN) begin
      int en;
      int pe;
      en = (mState == 0) ? 1 : 0;
      pe = (mState == 2) ? 0 : (mState == 1) ? mSaved : int'(pllReq);
      chk(stat == mState[1:0], "R7 stat", stat, mState);
      chk(cpuClkEn == en && flashClkEn == en && perClkEn == en, "R3 enables", cpuClkEn, en);
      chk(oscEn && subPerClkEn, "R3 always-on", oscEn, 1);
      chk(pllEn == pe[0], "R10 pll", pllEn, pe);
      chk(stopFlag == mStop[0], "R8 stop", stopFlag, mStop);
      chk(clkSelSub == mSel[0], "R9 sel", clkSelSub, mSel);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic s, input logic [1:0] nd, input logic id);
    ctlMode = m; ctlStop = s; ctlNmiDis = nd; ctlIntDis = id; ctlWrEn = 1'b1;
    step();
    ctlWrEn = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step();
    chk(stat == 2'd0 && cpuClkEn && !stopFlag && !clkSelSub, "R11 reset state", stat, 0);

    // R1 entry, R9/R10 context
    onSubclk = 1'b1; pllReq = 1'b1;
    wr(2'b00, 1'b1, 2'b01, 1'b0);
    chk(stopFlag == 1'b1 && stat == 2'd0, "R1 stop written", stopFlag, 1);
    step();
    chk(stat == 2'd2, "R1 idle entered", stat, 2);
    chk(!cpuClkEn && !flashClkEn && !perClkEn && oscEn && subPerClkEn, "R3 gated", cpuClkEn, 0);
    chk(!stopFlag, "R8 stop cleared on entry", stopFlag, 0);
    chk(!pllEn && clkSelSub, "R10 pll off in idle", pllEn, 0);
    pllReq = 1'b0;

    // R4 masked external, R5 disabled nmi line 0
    extIrq = 8'h01; extMask = 8'hFF;
    step(2);
    chk(stat == 2'd2, "R4 masked ext ignored", stat, 2);
    extIrq = '0; nmiReq = 2'b01;
    step(2);
    chk(stat == 2'd2, "R5 disabled nmi ignored", stat, 2);
    nmiReq = 2'b00;

    // R7 wake delay via unmasked external pin 0
    extMask = 8'hFE; extIrq = 8'h01;
    step();
    chk(stat == 2'd1, "R7 wake begins", stat, 1);
    chk(pllEn == 1'b1, "R10 saved pll restored", pllEn, 1);
    extIrq = '0; nmiReq = 2'b10;
    step(11);
    chk(stat == 2'd1, "R7 still waking after 11", stat, 1);
    nmiReq = 2'b00;
    step();
    chk(stat == 2'd0 && cpuClkEn, "R7 run after 12", stat, 0);
    chk(clkSelSub == 1'b1, "R9 stays subclock", clkSelSub, 1);
    chk(pllEn == 1'b0, "R10 pll follows request", pllEn, 0);
    extMask = '1;

    // R2 invalid mode / not on subclock
    wr(2'b01, 1'b1, 2'b00, 1'b0);
    step();
    chk(stat == 2'd0 && stopFlag, "R2 mode 01 no entry", stat, 0);
    wr(2'b11, 1'b1, 2'b00, 1'b0);
    step();
    chk(stat == 2'd0 && stopFlag, "R2 mode 11 no entry", stat, 0);
    onSubclk = 1'b0;
    wr(2'b10, 1'b1, 2'b00, 1'b0);
    step();
    chk(stat == 2'd0 && stopFlag, "R2 main clock no entry", stat, 0);
    wr(2'b10, 1'b0, 2'b00, 1'b0);
    onSubclk = 1'b1;
    step();
    chk(stat == 2'd0, "R2 stop cleared stays run", stat, 0);

    // R6 pending request aborts entry
    intMask = 4'b0000; intIrq = 4'b0100;
    wr(2'b10, 1'b1, 2'b00, 1'b0);
    step();
    chk(stat == 2'd0 && cpuClkEn, "R6 abort stays run", stat, 0);
    chk(!stopFlag, "R6 R8 stop cleared on abort", stopFlag, 0);
    intIrq = '0;

    // R5 interrupt disable, R4 nmi line 1, R11 reset in wake
    wr(2'b00, 1'b1, 2'b00, 1'b1);
    step();
    chk(stat == 2'd2, "R1 idle again", stat, 2);
    intIrq = 4'b1000; extMask = 8'h00; extIrq = 8'h80;
    step(2);
    chk(stat == 2'd2, "R5 int disable holds idle", stat, 2);
    intIrq = '0; extIrq = '0; extMask = '1; nmiReq = 2'b10;
    step();
    chk(stat == 2'd1, "R4 nmi line 1 wakes", stat, 1);
    nmiReq = 2'b00;
    step(3);
    rstN = 1'b0;
    #1;
    chk(stat == 2'd0 && cpuClkEn && !clkSelSub && !stopFlag, "R11 async reset", stat, 0);
    step();
    rstN = 1'b1;
    step();

    // R8 writes ignored in idle, R4 internal line
    intMask = 4'b1111; intIrq = 4'b0010;
    wr(2'b10, 1'b1, 2'b00, 1'b0);
    step();
    chk(stat == 2'd2, "R4 masked int idle", stat, 2);
    wr(2'b00, 1'b0, 2'b11, 1'b1);
    intMask = 4'b1101;
    step();
    chk(stat == 2'd1, "R8 idle write ignored, R4 int wakes", stat, 1);
    intIrq = '0;
    step(12);
    chk(stat == 2'd0, "R7 back to run", stat, 0);

    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule